// File: doc/BRIEF.md
# LAN Controller Host Register Port

This block is the host-facing register set of a LAN controller. A host processor reaches it through a small slave port: a select line, a data strobe, a read/write flag and a one-bit address that picks either the register pointer or the data register. The port handshakes like a valid/ready pair. The host raises select and strobe (its "valid") and holds them. The block answers with ready one clock later and keeps ready high until the host drops strobe. Ready is the only back-pressure: the host must keep its address, direction and write data stable until it sees ready.

Four registers sit behind the pointer. The command/status register carries the status flags, the interrupt enable and the command bits. Two further registers hold the low and high parts of the initialization address, and the last is a three-bit bus configuration word. The controller core reports events to the block as one-cycle pulses, and these set sticky status flags. Software clears a flag by writing 1 to it. A software stop request is held in a latch and takes effect only after the current host cycle has ended. When it takes effect, the block pulses a core reset and clears the command/status register and the configuration word. The initialization address survives the stop. Reads return a copy taken at the start of the cycle, so flag changes cannot disturb the data while the host samples it.

Top module: `lan_csr_port`

## Requirements
- R1: After power-on reset, the pointer is 0, ready, irq and core_rst are 0, and the command/status register reads 0x0004: the stop bit (bit 2) is 1 and every other bit is 0.
- R2: A cycle starts when select and strobe are both high while the port is idle. Ready goes high on the next clock and stays high until strobe is seen low, and ready is low on the clock after that.
- R3: A write of 1 to bit 2 while the stop bit is 0 leaves the register unchanged while ready is high. On the clock on which the cycle ends, core_rst pulses for one cycle. From then on the register reads 0x0004.
- R4: A write of 1 to bit 2 while the stop bit is already 1 changes no bit of the register, whatever its other bits hold, and it does not pulse core_rst.
- R5: The low initialization address (16 bits) and the high initialization address (low 8 bits, upper bits read 0) keep their values through a stop.
- R6: The configuration word (bit 0 hold mode, bit 1 active-low address strobe, bit 2 byte swap) reads 0 after a stop.
- R7: Read data is captured when the cycle starts and stays constant while ready is high, even if events arrive during the cycle.
- R8: The interrupt enable (bit 6) is read/write at any time, including while the stop bit is 1.
- R9: Event input bit k (k = 0..6) sets register bit 8+k. The flags are, from bit 14 down to bit 8: babble, collision error, missed frame, memory error, receive, transmit and init done. A write of 1 to a flag clears it, unless an event for the same flag arrives in the same clock, in which case the flag is set.
- R10: Bit 15 is the OR of bits 14..11. Bit 7 is the OR of bits 14 and 12..8. irq is high exactly when bit 7 and bit 6 are both 1.
- R11: Writing 1 to init (bit 0) or start (bit 1) sets that bit and clears stop. Start also sets receive-on (bit 5) and transmit-on (bit 4), and bit 3 is a sticky transmit demand. If a write also has bit 2 set, the stop handling wins and the other bits are ignored.
- R12: Address 1 reads and writes the pointer (2 bits). Address 0 accesses the register the pointer selects: 0 command/status, 1 low initialization address, 2 high initialization address, 3 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Host chip select |
| bus_strobe | input | 1 | Host data strobe, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 1 = pointer, 0 = selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while ready is high |
| bus_ready | output | 1 | Cycle acknowledge |
| ev_pulse | input | 7 | One-cycle status event pulses |
| irq | output | 1 | Interrupt request |
| core_rst | output | 1 | One-cycle reset request to the core |
| init_lo | output | 16 | Low initialization address |
| init_hi | output | 8 | High initialization address |
| cfg_swap | output | 1 | Byte swap configuration |
| cfg_latch_low | output | 1 | Active-low address strobe configuration |
| cfg_hold_mode | output | 1 | Hold handshake configuration |
| ctl_init | output | 1 | Init command bit |
| ctl_strt | output | 1 | Start command bit |
| ctl_tdmd | output | 1 | Transmit demand bit |
| ctl_stop | output | 1 | Stop state |

## Verification
Some behaviours are checked by assertions on every cycle. Ready falls after strobe is released. The read copy holds still while ready is high. core_rst never coincides with ready. A stop leaves both initialization address registers untouched and zeroes the configuration word. irq never rises without both the enable and the summary bit, and a stop request can only be latched while the stop bit is clear. Other behaviours only the bench scenarios can show. These are the exact register values after sweeps over every event input. They also include a flag clear that lands in the same clock as an event, the stop-priority cases, and addressing through every pointer value.

// File: rtl/lancsr_pkg.sv
package lancsr_pkg;
  localparam int DW      = 16;
  localparam int NEV     = 7;
  localparam int RAP_W   = 2;
  localparam int B_ERR   = 15;
  localparam int B_STLO  = 8;
  localparam int B_INTR  = 7;
  localparam int B_INEA  = 6;
  localparam int B_RXON  = 5;
  localparam int B_TXON  = 4;
  localparam int B_TDMD  = 3;
  localparam int B_STOP  = 2;
  localparam int B_STRT  = 1;
  localparam int B_INIT  = 0;

  typedef enum logic {P_IDLE, P_HOLD} port_state_e;

  typedef struct packed {
    logic swap;
    logic latch_low;
    logic hold_mode;
  } cfg_t;
endpackage

// File: rtl/csr_bus_port.sv
module csr_bus_port
  import lancsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          strobe,
  input  logic [DW-1:0] rd_word,
  output logic          start,
  output logic          cycle_end,
  output logic          ready,
  output logic [DW-1:0] rdata
);
  port_state_e st_q;
  logic [DW-1:0] shadow_q;

  assign start     = (st_q == P_IDLE) && sel && strobe;
  assign cycle_end = (st_q == P_HOLD) && !strobe;
  assign ready     = (st_q == P_HOLD);
  assign rdata     = shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= P_IDLE;
      shadow_q <= '0;
    end else begin
      if (start) begin
        st_q     <= P_HOLD;
        shadow_q <= rd_word;
      end else if (cycle_end) begin
        st_q <= P_IDLE;
      end
    end
  end

  a_r2_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ready);
  a_r2_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !strobe) |=> !ready);
  a_r7_shadow_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(rdata));
endmodule

// File: rtl/csr0_core.sv
module csr0_core
  import lancsr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  input  logic [NEV-1:0] ev,
  input  logic           cycle_end,
  output logic [DW-1:0]  csr0,
  output logic           stop_fire,
  output logic           rst_req,
  output logic           irq
);
  logic [NEV-1:0] stat_q, stat_d;
  logic inea_q, inea_d, rx_q, rx_d, tx_q, tx_d, tdmd_q, tdmd_d;
  logic stop_q, stop_d, strt_q, strt_d, init_q, init_d;
  logic pend_q, pend_d, rst_q;
  logic err_w, intr_w;
  logic cmd_wr;

  assign stop_fire = cycle_end && pend_q;
  assign cmd_wr    = wr_en && !wdata[B_STOP];

  // per-flag write-one-to-clear with event priority
  for (genvar k = 0; k < NEV; k++) begin : g_flag
    always_comb begin
      stat_d[k] = stat_q[k];
      if (cmd_wr && wdata[B_STLO+k]) stat_d[k] = 1'b0;
      if (ev[k])                     stat_d[k] = 1'b1;
      if (stop_fire)                 stat_d[k] = 1'b0;
    end
  end

  always_comb begin
    inea_d = inea_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    tdmd_d = tdmd_q;
    stop_d = stop_q;
    strt_d = strt_q;
    init_d = init_q;
    pend_d = pend_q;
    if (wr_en && wdata[B_STOP]) begin
      if (!stop_q) pend_d = 1'b1;
    end else if (cmd_wr) begin
      inea_d = wdata[B_INEA];
      if (wdata[B_INIT]) begin
        init_d = 1'b1;
        stop_d = 1'b0;
      end
      if (wdata[B_STRT]) begin
        strt_d = 1'b1;
        rx_d   = 1'b1;
        tx_d   = 1'b1;
        stop_d = 1'b0;
      end
      if (wdata[B_TDMD]) tdmd_d = 1'b1;
    end
    if (stop_fire) begin
      inea_d = 1'b0;
      rx_d   = 1'b0;
      tx_d   = 1'b0;
      tdmd_d = 1'b0;
      strt_d = 1'b0;
      init_d = 1'b0;
      stop_d = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      inea_q <= 1'b0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      tdmd_q <= 1'b0;
      stop_q <= 1'b1;
      strt_q <= 1'b0;
      init_q <= 1'b0;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      inea_q <= inea_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      tdmd_q <= tdmd_d;
      stop_q <= stop_d;
      strt_q <= strt_d;
      init_q <= init_d;
      pend_q <= pend_d;
      rst_q  <= stop_fire;
    end
  end

  // stat_q[6]=babble .. [3]=memory error; collision (5) is not an interrupt source
  assign err_w  = |stat_q[NEV-1:NEV-4];
  assign intr_w = stat_q[6] | (|stat_q[4:0]);
  assign csr0   = {err_w, stat_q, intr_w, inea_q, rx_q, tx_q, tdmd_q, stop_q, strt_q, init_q};
  assign irq    = intr_w && inea_q;
  assign rst_req = rst_q;

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (csr0[B_INEA] && csr0[B_INTR]));
  a_r4_latch_only_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !stop_q);
  a_r9_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev) && !stop_fire) |=> ((stat_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/csr_cfg_regs.sv
module csr_cfg_regs
  import lancsr_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ptr,
  input  logic             wr_reg,
  input  logic [DW-1:0]    wdata,
  input  logic             stop_fire,
  output logic [RAP_W-1:0] rap,
  output logic [DW-1:0]    lo_q,
  output logic [HI_W-1:0]  hi_q,
  output cfg_t             cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rap   <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_ptr) rap <= wdata[RAP_W-1:0];
      if (wr_reg) begin
        case (rap)
          2'd1:    lo_q  <= wdata;
          2'd2:    hi_q  <= wdata[HI_W-1:0];
          2'd3:    cfg_q <= cfg_t'(wdata[2:0]);
          default: ;
        endcase
      end
      if (stop_fire) cfg_q <= '0;
    end
  end

  a_r5_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> ($stable(lo_q) && $stable(hi_q)));
  a_r6_cfg_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> (cfg_q == '0));
endmodule

// File: rtl/lan_csr_port.sv
module lan_csr_port
  import lancsr_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_strobe,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic            bus_ready,
  input  logic [6:0]      ev_pulse,
  output logic            irq,
  output logic            core_rst,
  output logic [15:0]     init_lo,
  output logic [HI_W-1:0] init_hi,
  output logic            cfg_swap,
  output logic            cfg_latch_low,
  output logic            cfg_hold_mode,
  output logic            ctl_init,
  output logic            ctl_strt,
  output logic            ctl_tdmd,
  output logic            ctl_stop
);
  logic start, cycle_end, stop_fire;
  logic wr_ptr, wr_reg, wr_c0;
  logic [DW-1:0] rd_word, csr0;
  logic [RAP_W-1:0] rap;
  cfg_t cfg;

  assign wr_ptr = start && bus_wr && bus_addr;
  assign wr_reg = start && bus_wr && !bus_addr;
  assign wr_c0  = wr_reg && (rap == '0);

  always_comb begin
    if (bus_addr) rd_word = DW'(rap);
    else begin
      case (rap)
        2'd0:    rd_word = csr0;
        2'd1:    rd_word = init_lo;
        2'd2:    rd_word = DW'(init_hi);
        default: rd_word = DW'(cfg);
      endcase
    end
  end

  csr_bus_port u_port (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .strobe(bus_strobe),
    .rd_word(rd_word), .start(start), .cycle_end(cycle_end),
    .ready(bus_ready), .rdata(bus_rdata)
  );

  csr0_core u_c0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_c0), .wdata(bus_wdata),
    .ev(ev_pulse), .cycle_end(cycle_end), .csr0(csr0),
    .stop_fire(stop_fire), .rst_req(core_rst), .irq(irq)
  );

  csr_cfg_regs #(.HI_W(HI_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .wr_reg(wr_reg),
    .wdata(bus_wdata), .stop_fire(stop_fire), .rap(rap),
    .lo_q(init_lo), .hi_q(init_hi), .cfg_q(cfg)
  );

  assign cfg_swap      = cfg.swap;
  assign cfg_latch_low = cfg.latch_low;
  assign cfg_hold_mode = cfg.hold_mode;
  assign ctl_init      = csr0[B_INIT];
  assign ctl_strt      = csr0[B_STRT];
  assign ctl_tdmd      = csr0[B_TDMD];
  assign ctl_stop      = csr0[B_STOP];

  a_r3_reset_outside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !bus_ready);
endmodule

// File: tb/sim_lan_csr_port.sv
module sim_lan_csr_port;
  logic clk = 0, rst_n = 0;
  logic sel = 0, strobe = 0, wr = 0, addr = 0;
  logic [15:0] wd = 0, rdata;
  logic ready, irq, core_rst;
  logic [6:0] ev = 0;
  logic [15:0] init_lo;
  logic [7:0] init_hi;
  logic cfg_swap, cfg_latch_low, cfg_hold_mode, ctl_init, ctl_strt, ctl_tdmd, ctl_stop;
  int checks = 0, errors = 0;
  bit done = 0;

  // model
  logic [6:0] m_stat = 0;
  logic m_inea = 0, m_rx = 0, m_tx = 0, m_tdmd = 0, m_stop = 1, m_strt = 0, m_init = 0;

  always #10 clk = ~clk;

  lan_csr_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_strobe(strobe), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata), .bus_ready(ready),
    .ev_pulse(ev), .irq(irq), .core_rst(core_rst), .init_lo(init_lo),
    .init_hi(init_hi), .cfg_swap(cfg_swap), .cfg_latch_low(cfg_latch_low),
    .cfg_hold_mode(cfg_hold_mode), .ctl_init(ctl_init), .ctl_strt(ctl_strt),
    .ctl_tdmd(ctl_tdmd), .ctl_stop(ctl_stop)
  );

  function automatic logic [15:0] exp0();
    logic e, n;
    e = |m_stat[6:3];
    n = m_stat[6] | (|m_stat[4:0]);
    return {e, m_stat, n, m_inea, m_rx, m_tx, m_tdmd, m_stop, m_strt, m_init};
  endfunction

  function automatic logic exp_irq();
    return (m_stat[6] | (|m_stat[4:0])) & m_inea;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one host cycle; ev_s is applied in the starting clock
  task automatic cyc(input logic w, input logic a, input logic [15:0] d, input logic [6:0] ev_s,
                     output logic [15:0] rd, output logic rs);
    @(negedge clk);
    sel = 1; strobe = 1; wr = w; addr = a; wd = d; ev = ev_s;
    @(negedge clk);
    ev = 0;
    rd = rdata;
    check("R2 ready after start", {15'b0, ready}, 16'h1);
    strobe = 0;
    @(negedge clk);
    rs = core_rst;
    check("R2 ready released", {15'b0, ready}, 16'h0);
    sel = 0; wr = 0;
  endtask

  task automatic mwrite0(input logic [15:0] d, input logic [6:0] ev_s);
    if (d[2]) begin
      if (!m_stop) begin
        m_stat = 0; m_inea = 0; m_rx = 0; m_tx = 0; m_tdmd = 0; m_strt = 0; m_init = 0; m_stop = 1;
      end
    end else begin
      m_stat = m_stat & ~d[14:8];
      m_inea = d[6];
      if (d[0]) begin m_init = 1; m_stop = 0; end
      if (d[1]) begin m_strt = 1; m_rx = 1; m_tx = 1; m_stop = 0; end
      if (d[3]) m_tdmd = 1;
    end
    m_stat = m_stat | ev_s;
  endtask

  task automatic rd0(input string req);
    logic [15:0] r; logic rs;
    cyc(0, 0, 0, 0, r, rs);
    check(req, r, exp0());
    check({req, " irq"}, {15'b0, irq}, {15'b0, exp_irq()});
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = 0;
    m_stat = m_stat | v;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic rs;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", {15'b0, ready}, 0);
    check("R1 irq", {15'b0, irq}, 0);
    check("R1 core_rst", {15'b0, core_rst}, 0);
    rst_n = 1;
    cyc(0, 1, 0, 0, r, rs);
    check("R1 pointer", r, 16'h0000);
    rd0("R1 csr0 after reset");

    // R8 enable while stopped
    cyc(1, 0, 16'h0040, 0, r, rs); mwrite0(16'h0040, 0);
    rd0("R8 enable while stopped");

    // R4 stop while stopped, with other bits also set
    cyc(1, 0, 16'h000B | 16'h0004, 0, r, rs);
    check("R4 no reset pulse", {15'b0, rs}, 0);
    mwrite0(16'h000F, 0);
    rd0("R4 stop while stopped");

    // R12 addressing sweep, values computed per pointer
    for (int p = 1; p < 4; p++) begin
      logic [15:0] v, e;
      v = 16'h1357 * p[15:0] + 16'h00A5;
      e = (p == 1) ? v : (p == 2) ? {8'h00, v[7:0]} : {13'b0, v[2:0]};
      cyc(1, 1, 16'(p), 0, r, rs);
      cyc(0, 1, 0, 0, r, rs);
      check("R12 pointer read", r, 16'(p));
      cyc(1, 0, v, 0, r, rs);
      cyc(0, 0, 0, 0, r, rs);
      check("R12 register read", r, e);
    end
    check("R12 cfg pins", {13'b0, cfg_swap, cfg_latch_low, cfg_hold_mode}, {13'b0, 3'(16'h1357*3 + 16'h00A5)});
    cyc(1, 1, 0, 0, r, rs);

    // R11 start clears stop
    cyc(1, 0, 16'h0042, 0, r, rs); mwrite0(16'h0042, 0);
    rd0("R11 start");
    check("R11 stop pin", {15'b0, ctl_stop}, 0);

    // R9 R10 sweep of every event bit
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k));
      rd0("R9 R10 event set");
      cyc(1, 0, 16'h0040 | 16'(1 << (8 + k)), 0, r, rs); mwrite0(16'h0040 | 16'(1 << (8 + k)), 0);
      rd0("R9 flag cleared");
    end
    // R10 pairs: every combination of two flags
    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 7; b++) begin
        pulse(7'((1 << a) | (1 << b)));
        rd0("R10 summary bits");
        cyc(1, 0, 16'h7F40, 0, r, rs); mwrite0(16'h7F40, 0);
      end
    // R9 clear and event in the same clock: event wins
    pulse(7'h04);
    cyc(1, 0, 16'h0440, 7'h04, r, rs); mwrite0(16'h0440, 7'h04);
    rd0("R9 event beats clear");

    // R7 read copy steady during cycle
    @(negedge clk); sel = 1; strobe = 1; wr = 0; addr = 0;
    @(negedge clk); r = rdata;
    ev = 7'h01;
    @(negedge clk); ev = 0; m_stat = m_stat | 7'h01;
    check("R7 hold 1", rdata, r);
    @(negedge clk);
    check("R7 hold 2", rdata, r);
    strobe = 0;
    @(negedge clk); sel = 0;
    rd0("R7 later read sees event");

    // R3 R5 R6 stop from running
    cyc(1, 1, 16'h0003, 0, r, rs);
    cyc(1, 0, 16'h0006, 0, r, rs);
    cyc(1, 1, 16'h0000, 0, r, rs);
    @(negedge clk); sel = 1; strobe = 1; wr = 1; addr = 0; wd = 16'h0004;
    @(negedge clk);
    check("R3 no change during cycle", {15'b0, ctl_stop}, 0);
    check("R3 no reset during cycle", {15'b0, core_rst}, 0);
    strobe = 0;
    @(negedge clk); sel = 0; wr = 0;
    check("R3 reset pulse", {15'b0, core_rst}, 1);
    @(negedge clk);
    check("R3 reset one cycle", {15'b0, core_rst}, 0);
    mwrite0(16'h0004, 0);
    rd0("R3 cleared after stop");
    check("R5 low address kept", init_lo, 16'h1357 + 16'h00A5);
    check("R5 high address kept", {8'h00, init_hi}, {8'h00, 8'(16'h1357*2 + 16'h00A5)});
    check("R6 cfg cleared", {13'b0, cfg_swap, cfg_latch_low, cfg_hold_mode}, 0);

    // R11 init clears stop; then stop plus init: stop wins
    cyc(1, 0, 16'h0001, 0, r, rs); mwrite0(16'h0001, 0);
    rd0("R11 init clears stop");
    cyc(1, 0, 16'h0005, 0, r, rs); mwrite0(16'h0005, 0);
    check("R11 stop wins pulse", {15'b0, rs}, 1);
    rd0("R11 stop wins");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule